// File: doc/BRIEF.md
# Authenticated Downlink Frame Serializer

This block takes the pieces of a finished authenticated-encryption result and sends them out one bit at a time as a framed downlink stream. The outputs are a serial data bit, a one-cycle strobe marking each new bit, and a valid flag. A frame starts with a run of alternating bits that lets the receiver lock on. A 16-bit sync word comes next, then the nonce (a 40-bit frame counter followed by the 16-bit message length in bytes), then the ciphertext bytes, then the 128-bit authentication tag. After the tag, a fixed alternating idle byte repeats until the next frame.

The block owns the frame counter. Software may load a starting value while no frame is in flight. Every accepted frame carries the current value and then advances it by one, whatever key the encryption engine used. Once a frame has gone out carrying the all-ones counter, the counter is spent and no further frame is accepted until reset. An inhibit input, driven by the surrounding control when it is in self-test, key zeroization, key entry or an error state, silences the line and drops any frame in flight.

The ciphertext is pulled from a show-ahead byte source: the block raises `ct_take` in the same cycle it uses `ct_byte`, and the source moves to the next byte after that clock edge. The tag and the length are sampled once, when the start request is accepted.

Top module: `auth_frame_tx`

## Requirements
- R1: An accepted frame is sent MSB-first in this order: 136 preamble bits alternating 1,0,1,... (first bit 1), then the sync word 0xEB90, the 40-bit counter, the 16-bit length in bytes, the `msg_len` ciphertext bytes, and the 128-bit tag.
- R2: When no frame is being sent, the line carries the idle byte 0x55 MSB-first (0,1,0,1,...). The pattern restarts with a 0 right after the last tag bit, after inhibit and after reset.
- R3: `ctr_load` with `ctr_seed` sets the counter when no frame is in progress. Each accepted frame carries the current counter value, and the counter then advances by 1 (carry across all 40 bits).
- R4: Sending a frame that carries counter 0xFF_FFFF_FFFF makes the counter spent. From then on, until reset, every start is rejected with a `req_err` pulse, and no frame is sent and no byte is taken.
- R5: A start whose `msg_len` is not a multiple of 8 or lies outside 24..312 is rejected. `req_err` is high for exactly the cycle after the start edge. No frame is sent, no byte is taken, and the counter is left unchanged.
- R6: From the cycle after `inhibit` is first sampled high, and for as long as it stays high, `tx_vld`, `tx_stb` and `tx_bit` are 0. A frame in flight is dropped, and its counter value is never reused. Starts seen during inhibit are ignored without `req_err`.
- R7: While a frame is in progress, `start` is ignored without `req_err`, and `ctr_load` is ignored.
- R8: When an accepted start and `ctr_load` fall in the same cycle, the start wins. The frame carries the old counter and the load is dropped.
- R9: `tx_stb` pulses once per bit, every `BIT_DIV` cycles. The first preamble bit appears one clock edge after the accepting edge. `ct_take` pulses exactly `msg_len` times per frame.
- R10: After reset, `tx_vld`, `tx_stb` and `req_err` are 0, the counter is 0 and not spent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit | input | 1 | Silences the line and drops any frame in flight |
| ctr_load | input | 1 | Load request for the frame counter |
| ctr_seed | input | 40 | Counter value to load |
| start | input | 1 | Request to send one frame |
| msg_len | input | 16 | Ciphertext length in bytes, sampled at start |
| msg_tag | input | 128 | Authentication tag, sampled at start |
| ct_byte | input | 8 | Current ciphertext byte from a show-ahead source |
| ct_take | output | 1 | Byte on `ct_byte` is consumed at this edge |
| tx_bit | output | 1 | Serial line bit |
| tx_stb | output | 1 | One-cycle pulse when a new bit is presented |
| tx_vld | output | 1 | Line is being driven (frame or idle) |
| req_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
Two functions that can land in the same cycle are a frame start and a counter load. The bench provokes this twice. Once it raises both at one edge while the block is idle, and the frame carries the old counter while the next frame shows that the load was dropped. Once it raises both in the middle of a ciphertext run, and the running frame must finish unchanged with no error pulse, while the following frame's counter shows that neither request took effect.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PRE,
    FS_SYNC,
    FS_CTR,
    FS_LEN,
    FS_BODY,
    FS_TAG
  } fs_state_e;
endpackage

// File: rtl/afs_nonce_ctr.sv
module afs_nonce_ctr #(
  parameter int CTR_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CTR_W-1:0] load_val,
  input  logic             use_en,
  output logic [CTR_W-1:0] value,
  output logic             spent
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      spent <= 1'b0;
    end else if (use_en) begin
      if (value == CTR_MAX) spent <= 1'b1;
      else value <= value + 1'b1;
    end else if (load_en) begin
      value <= load_val;
    end
  end
endmodule

// File: rtl/afs_bit_pacer.sv
module afs_bit_pacer #(
  parameter int BIT_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic kick,
  output logic tick
);
  generate
    if (BIT_DIV == 1) begin : g_full_rate
      assign tick = !hold;
    end else begin : g_divided
      localparam int CW = $clog2(BIT_DIV);
      logic [CW-1:0] cnt;
      logic          kick_q;

      assign tick = !hold && (kick_q || (cnt == CW'(BIT_DIV - 1)));

      always_ff @(posedge clk) begin
        if (rst || hold) begin
          cnt    <= '0;
          kick_q <= 1'b0;
        end else begin
          kick_q <= kick;
          if (tick) cnt <= '0;
          else cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq
  import afs_pkg::*;
#(
  parameter int          CTR_W     = 40,
  parameter int          LEN_W     = 16,
  parameter int          TAG_W     = 128,
  parameter int          PRE_BITS  = 136,
  parameter int          SYNC_W    = 16,
  parameter logic [15:0] SYNC_WORD = 16'hEB90,
  parameter logic [7:0]  IDLE_BYTE = 8'h55,
  parameter int          MAX_BYTES = 312
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             accept,
  input  logic [CTR_W-1:0] ctr_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [7:0]       body_byte,
  output logic             body_take,
  output logic             ser_bit,
  output logic             ser_stb,
  output logic             ser_vld,
  output logic             busy
);
  localparam int FW       = TAG_W;
  localparam int BODY_MAX = MAX_BYTES * 8;
  localparam int SPAN_A   = (BODY_MAX > PRE_BITS) ? BODY_MAX : PRE_BITS;
  localparam int SPAN     = (SPAN_A > TAG_W) ? SPAN_A : TAG_W;
  localparam int IW       = $clog2(SPAN + 1);
  localparam int BW       = LEN_W + 3;

  fs_state_e        st;
  logic [IW-1:0]    idx;
  logic [FW-1:0]    fsr;
  logic [6:0]       bsr;
  logic [2:0]       ipos;
  logic [CTR_W-1:0] ctr_q;
  logic [LEN_W-1:0] len_q;
  logic [TAG_W-1:0] tag_q;

  logic             last;
  logic             first;
  logic             nxt_bit;
  logic [BW-1:0]    body_last;

  assign body_last = {len_q, 3'b000} - BW'(1);
  assign first     = (idx[2:0] == 3'd0);
  assign busy      = (st != FS_IDLE);
  assign body_take = tick && (st == FS_BODY) && first;

  always_comb begin
    case (st)
      FS_PRE:  last = (idx == IW'(PRE_BITS - 1));
      FS_SYNC: last = (idx == IW'(SYNC_W - 1));
      FS_CTR:  last = (idx == IW'(CTR_W - 1));
      FS_LEN:  last = (idx == IW'(LEN_W - 1));
      FS_BODY: last = (BW'(idx) == body_last);
      FS_TAG:  last = (idx == IW'(TAG_W - 1));
      default: last = 1'b1;
    endcase
  end

  always_comb begin
    case (st)
      FS_IDLE: nxt_bit = IDLE_BYTE[~ipos];
      FS_PRE:  nxt_bit = ~idx[0];
      FS_BODY: nxt_bit = first ? body_byte[7] : bsr[6];
      default: nxt_bit = fsr[FW-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      idx     <= '0;
      fsr     <= '0;
      bsr     <= '0;
      ipos    <= '0;
      ctr_q   <= '0;
      len_q   <= '0;
      tag_q   <= '0;
      ser_bit <= 1'b0;
      ser_stb <= 1'b0;
      ser_vld <= 1'b0;
    end else if (hold) begin
      st      <= FS_IDLE;
      idx     <= '0;
      ipos    <= '0;
      ser_bit <= 1'b0;
      ser_stb <= 1'b0;
      ser_vld <= 1'b0;
    end else begin
      ser_stb <= tick;
      if (tick) begin
        ser_vld <= 1'b1;
        ser_bit <= nxt_bit;
        idx     <= last ? '0 : idx + 1'b1;
        case (st)
          FS_IDLE: ipos <= ipos + 1'b1;
          FS_PRE: begin
            if (last) begin
              st  <= FS_SYNC;
              fsr <= {SYNC_WORD, {(FW - SYNC_W){1'b0}}};
            end
          end
          FS_SYNC: begin
            if (last) begin
              st  <= FS_CTR;
              fsr <= {ctr_q, {(FW - CTR_W){1'b0}}};
            end else fsr <= fsr << 1;
          end
          FS_CTR: begin
            if (last) begin
              st  <= FS_LEN;
              fsr <= {len_q, {(FW - LEN_W){1'b0}}};
            end else fsr <= fsr << 1;
          end
          FS_LEN: begin
            if (last) st <= FS_BODY;
            else fsr <= fsr << 1;
          end
          FS_BODY: begin
            bsr <= first ? body_byte[6:0] : (bsr << 1);
            if (last) begin
              st  <= FS_TAG;
              fsr <= tag_q;
            end
          end
          FS_TAG: begin
            if (last) begin
              st   <= FS_IDLE;
              ipos <= '0;
            end else fsr <= fsr << 1;
          end
          default: st <= FS_IDLE;
        endcase
      end
      if (accept) begin
        st    <= FS_PRE;
        idx   <= '0;
        ctr_q <= ctr_in;
        len_q <= len_in;
        tag_q <= tag_in;
      end
    end
  end
endmodule

// File: rtl/auth_frame_tx.sv
module auth_frame_tx #(
  parameter int          CTR_W     = 40,
  parameter int          LEN_W     = 16,
  parameter int          TAG_W     = 128,
  parameter int          PRE_BITS  = 136,
  parameter int          SYNC_W    = 16,
  parameter logic [15:0] SYNC_WORD = 16'hEB90,
  parameter logic [7:0]  IDLE_BYTE = 8'h55,
  parameter int          MIN_BYTES = 24,
  parameter int          MAX_BYTES = 312,
  parameter int          BLK_BYTES = 8,
  parameter int          BIT_DIV   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  input  logic             ctr_load,
  input  logic [CTR_W-1:0] ctr_seed,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [TAG_W-1:0] msg_tag,
  input  logic [7:0]       ct_byte,
  output logic             ct_take,
  output logic             tx_bit,
  output logic             tx_stb,
  output logic             tx_vld,
  output logic             req_err
);
  logic             busy;
  logic             spent;
  logic [CTR_W-1:0] ctr_now;
  logic             len_ok;
  logic             idle_ok;
  logic             accept;
  logic             reject;
  logic             load_en;
  logic             tick;

  assign len_ok  = (msg_len % LEN_W'(BLK_BYTES) == '0)
                && (msg_len >= LEN_W'(MIN_BYTES))
                && (msg_len <= LEN_W'(MAX_BYTES));
  assign idle_ok = !busy && !inhibit;
  assign accept  = start && idle_ok && len_ok && !spent;
  assign reject  = start && idle_ok && (!len_ok || spent);
  assign load_en = ctr_load && !busy && !accept;

  always_ff @(posedge clk) begin
    if (rst) req_err <= 1'b0;
    else req_err <= reject;
  end

  afs_nonce_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (ctr_seed),
    .use_en   (accept),
    .value    (ctr_now),
    .spent    (spent)
  );

  afs_bit_pacer #(.BIT_DIV(BIT_DIV)) u_pace (
    .clk  (clk),
    .rst  (rst),
    .hold (inhibit),
    .kick (accept),
    .tick (tick)
  );

  afs_frame_seq #(
    .CTR_W     (CTR_W),
    .LEN_W     (LEN_W),
    .TAG_W     (TAG_W),
    .PRE_BITS  (PRE_BITS),
    .SYNC_W    (SYNC_W),
    .SYNC_WORD (SYNC_WORD),
    .IDLE_BYTE (IDLE_BYTE),
    .MAX_BYTES (MAX_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .hold      (inhibit),
    .tick      (tick),
    .accept    (accept),
    .ctr_in    (ctr_now),
    .len_in    (msg_len),
    .tag_in    (msg_tag),
    .body_byte (ct_byte),
    .body_take (ct_take),
    .ser_bit   (tx_bit),
    .ser_stb   (tx_stb),
    .ser_vld   (tx_vld),
    .busy      (busy)
  );
endmodule

// File: rtl/afs_chk.sv
module afs_chk #(
  parameter int CTR_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             inhibit,
  input logic             start,
  input logic             ctr_load,
  input logic             ct_take,
  input logic             tx_bit,
  input logic             tx_stb,
  input logic             tx_vld,
  input logic             req_err,
  input logic             accept,
  input logic             busy,
  input logic             spent,
  input logic [CTR_W-1:0] ctr_now
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!tx_vld && !tx_stb && !tx_bit));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
    req_err |-> $past(start));

  assert_take_live_R9: assert property (@(posedge clk) disable iff (rst)
    ct_take |-> (tx_vld && busy));

  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && (ctr_now != CTR_MAX)) |=> (ctr_now == $past(ctr_now) + 1'b1));

  assert_spent_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    spent |=> spent);

  assert_spent_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    spent |-> !accept);

  assert_load_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && ctr_load) |=> $stable(ctr_now));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!tx_vld && !tx_stb && !req_err && !spent));
endmodule

bind auth_frame_tx afs_chk #(.CTR_W(CTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inhibit  (inhibit),
  .start    (start),
  .ctr_load (ctr_load),
  .ct_take  (ct_take),
  .tx_bit   (tx_bit),
  .tx_stb   (tx_stb),
  .tx_vld   (tx_vld),
  .req_err  (req_err),
  .accept   (accept),
  .busy     (busy),
  .spent    (spent),
  .ctr_now  (ctr_now)
);

// File: tb/tb_auth_frame_tx.sv
module tb_auth_frame_tx;
  localparam int CLK_NS = 10;
  localparam int HDR    = 136 + 16 + 40 + 16;

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  seed;
    logic        ld;
    logic [39:0] val;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd24,  8'd1, 1'b1, 40'h00_0000_0010},
    '{16'd312, 8'd2, 1'b0, 40'h0},
    '{16'd64,  8'd3, 1'b1, 40'h12_3456_789A},
    '{16'd40,  8'd4, 1'b0, 40'h0},
    '{16'd200, 8'd5, 1'b1, 40'h00_FFFF_FFFF},
    '{16'd32,  8'd6, 1'b0, 40'h0}
  };

  logic         clk = 1'b0;
  logic         rst, inhibit, ctr_load, start;
  logic [39:0]  ctr_seed;
  logic [15:0]  msg_len;
  logic [127:0] msg_tag;
  logic [7:0]   ct_byte;
  logic         ct_take, tx_bit, tx_stb, tx_vld, req_err;

  always #(CLK_NS / 2) clk = ~clk;

  auth_frame_tx dut (
    .clk(clk), .rst(rst), .inhibit(inhibit), .ctr_load(ctr_load),
    .ctr_seed(ctr_seed), .start(start), .msg_len(msg_len), .msg_tag(msg_tag),
    .ct_byte(ct_byte), .ct_take(ct_take), .tx_bit(tx_bit), .tx_stb(tx_stb),
    .tx_vld(tx_vld), .req_err(req_err)
  );

  logic [7:0] ct_mem [0:511];
  int         ct_idx;
  logic       ct_clr;
  logic       cap [0:3071];
  int         ncap;
  int         total = 0;
  int         bad   = 0;
  logic [39:0] exp_ctr;

  assign ct_byte = ct_mem[ct_idx[8:0]];

  always @(posedge clk) begin
    if (ct_clr) ct_idx <= 0;
    else if (ct_take) ct_idx <= ct_idx + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [127:0] mk_tag(input int seed);
    logic [127:0] t;
    for (int k = 0; k < 4; k++)
      t[k*32 +: 32] = (32'(seed) * 32'd1000 + 32'(k)) * 32'h0100_0193 ^ 32'hA5A5_0000;
    return t;
  endfunction

  function automatic logic [7:0] mk_byte(input int seed, input int i);
    return 8'(i * 29 + seed * 7 + 3);
  endfunction

  function automatic logic [127:0] field(input int off, input int n);
    logic [127:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[126:0], cap[off + k]};
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1; inhibit = 1'b0; ctr_load = 1'b0; start = 1'b0; ct_clr = 1'b1;
    ctr_seed = '0; msg_len = '0; msg_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0; ct_clr = 1'b0;
  endtask

  task automatic load_ctr(input logic [39:0] v);
    @(negedge clk); ctr_load = 1'b1; ctr_seed = v;
    @(negedge clk); ctr_load = 1'b0;
  endtask

  // Sends one frame, optionally with a load at the start edge or a start+load poke mid-frame.
  task automatic run_frame(input int len, input int seed, input logic ld_with,
                           input logic [39:0] ld_val, input int poke,
                           output logic err_seen);
    int   cycles = 0;
    int   want   = HDR + len * 8 + 128 + 16;
    logic pend   = 1'b0;
    logic poked  = 1'b0;
    for (int i = 0; i < len; i++) ct_mem[i] = mk_byte(seed, i);
    @(negedge clk);
    msg_len = 16'(len); msg_tag = mk_tag(seed); start = 1'b1; ct_clr = 1'b1;
    ctr_load = ld_with; ctr_seed = ld_val;
    @(negedge clk);
    start = 1'b0; ct_clr = 1'b0; ctr_load = 1'b0;
    err_seen = req_err;
    ncap = 0;
    while (ncap < want && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (pend) begin start = 1'b0; ctr_load = 1'b0; pend = 1'b0; end
      if (req_err) err_seen = 1'b1;
      if (tx_stb) begin cap[ncap] = tx_bit; ncap++; end
      if (ncap == poke && !poked) begin
        start = 1'b1; ctr_load = 1'b1; ctr_seed = 40'hAA_AAAA_AAAA;
        poked = 1'b1; pend = 1'b1;
      end
    end
    chk("R9", "frame completed", 128'(ncap), 128'(want));
  endtask

  task automatic check_frame(input int len, input int seed, input logic [39:0] ectr);
    int pre_bad = 0;
    int body_bad = 0;
    for (int i = 0; i < 136; i++) if (cap[i] !== ~1'(i % 2)) pre_bad++;
    chk("R1", "preamble mismatches", 128'(pre_bad), 128'd0);
    chk("R1", "sync word", field(136, 16), 128'hEB90);
    chk("R3", "counter field", field(152, 40), 128'(ectr));
    chk("R1", "length field", field(192, 16), 128'(len));
    for (int i = 0; i < len; i++)
      if (field(HDR + i * 8, 8) !== 128'(mk_byte(seed, i))) body_bad++;
    chk("R1", "ciphertext byte mismatches", 128'(body_bad), 128'd0);
    chk("R1", "tag field", field(HDR + len * 8, 128), mk_tag(seed));
    chk("R2", "idle after frame", field(HDR + len * 8 + 128, 16), 128'h5555);
    chk("R9", "bytes taken", 128'(ct_idx), 128'(len));
  endtask

  task automatic try_reject(input int len, input string req);
    @(negedge clk); msg_len = 16'(len); start = 1'b1; ct_clr = 1'b1;
    @(negedge clk); start = 1'b0; ct_clr = 1'b0;
    chk(req, "error pulse on rejected start", 128'(req_err), 128'd1);
    @(negedge clk);
    chk(req, "error pulse lasts one cycle", 128'(req_err), 128'd0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 190000);
    total++; bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic e;
    // R10: reset state
    do_reset();
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "tx_vld in reset", 128'(tx_vld), 128'd0);
    chk("R10", "tx_stb in reset", 128'(tx_stb), 128'd0);
    chk("R10", "req_err in reset", 128'(req_err), 128'd0);
    rst = 1'b0;
    // R10: counter starts at 0
    run_frame(24, 9, 1'b0, '0, -1, e);
    check_frame(24, 9, 40'h0);
    exp_ctr = 40'h1;

    // R1 R2 R3 R9: table of frames
    for (int v = 0; v < 6; v++) begin
      if (VECS[v].ld) begin
        load_ctr(VECS[v].val);
        exp_ctr = VECS[v].val;
      end
      run_frame(int'(VECS[v].len), int'(VECS[v].seed), 1'b0, '0, -1, e);
      chk("R1", "no error on good start", 128'(e), 128'd0);
      check_frame(int'(VECS[v].len), int'(VECS[v].seed), exp_ctr);
      exp_ctr = exp_ctr + 1'b1;
    end

    // R5: bad lengths
    try_reject(16, "R5");
    try_reject(320, "R5");
    try_reject(100, "R5");
    try_reject(0, "R5");
    repeat (600) @(negedge clk);
    chk("R5", "no bytes taken after rejects", 128'(ct_idx), 128'd0);
    run_frame(24, 11, 1'b0, '0, -1, e);
    check_frame(24, 11, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;

    // R7: start and load mid-frame ignored
    run_frame(48, 12, 1'b0, '0, HDR + 100, e);
    chk("R7", "no error for start during frame", 128'(e), 128'd0);
    check_frame(48, 12, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;
    run_frame(24, 13, 1'b0, '0, -1, e);
    check_frame(24, 13, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;

    // R8: start and load in the same idle cycle
    run_frame(32, 14, 1'b1, 40'h55_0000_0000, -1, e);
    check_frame(32, 14, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;
    run_frame(24, 15, 1'b0, '0, -1, e);
    check_frame(24, 15, exp_ctr);
    exp_ctr = exp_ctr + 1'b1;

    // R6: inhibit mid-frame
    begin
      int noisy = 0;
      int errs = 0;
      @(negedge clk); msg_len = 16'd64; msg_tag = mk_tag(16); start = 1'b1; ct_clr = 1'b1;
      @(negedge clk); start = 1'b0; ct_clr = 1'b0;
      repeat (300) @(negedge clk);
      inhibit = 1'b1;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (tx_vld || tx_stb || tx_bit) noisy++;
        if (req_err) errs++;
        start = (c == 3);
      end
      start = 1'b0;
      @(negedge clk);
      if (req_err) errs++;
      inhibit = 1'b0;
      chk("R6", "line activity during inhibit", 128'(noisy), 128'd0);
      chk("R6", "errors for start during inhibit", 128'(errs), 128'd0);
      exp_ctr = exp_ctr + 1'b1;
      run_frame(40, 17, 1'b0, '0, -1, e);
      check_frame(40, 17, exp_ctr);
      exp_ctr = exp_ctr + 1'b1;
    end

    // R4: counter exhaustion
    load_ctr(40'hFF_FFFF_FFFF);
    run_frame(24, 18, 1'b0, '0, -1, e);
    check_frame(24, 18, 40'hFF_FFFF_FFFF);
    try_reject(24, "R4");
    repeat (600) @(negedge clk);
    chk("R4", "no bytes taken when spent", 128'(ct_idx), 128'd0);

    // R10: reset clears spent and counter
    do_reset();
    run_frame(24, 19, 1'b0, '0, -1, e);
    chk("R10", "start accepted after reset", 128'(e), 128'd0);
    check_frame(24, 19, 40'h0);

    finish_run();
  end
endmodule